// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Rising-Edge Capture

This block is a small register-mapped general-purpose I/O port. Each of its seven pins is set as an input or an output by a direction register. An input pin works in one of two ways. In live mode its status bit shows the synchronized pin level. In capture mode its status bit is a sticky flag that a rising edge sets. One status address serves both directions. For an output pin, writing that address sets the driven level, and reading it returns the last value written.

Host software reaches the port through a simple single-cycle register bus. A read of the status address clears every armed capture flag, whether or not that pin's interrupt is enabled. A read of any other address, including the chip's global interrupt status address, leaves the flags alone. A single interrupt line is the OR of the status bits of input pins whose enable bit is set.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the direction, enable, mode and output registers are all 0, all capture flags are cleared, `pin_oe` and `pin_out` are 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Register addresses are: direction 0x2C, interrupt enable 0x2D, mode 0x2E, status 0x2F. Bit n of each register belongs to pin n for n = 0..6. Bit 7 always reads as 0. `bus_rdata` is loaded at the clock edge that samples a read (`bus_sel`=1, `bus_wr`=0) and holds until the next read. Unmapped addresses read as 0.
- R3: For an input pin in live mode (mode bit 0), the status bit equals the pin level after a two-flop synchronizer, and a read never clears it.
- R4: For an input pin in capture mode (mode bit 1), a rising edge of the synchronized level sets a sticky status bit. A falling edge does not set it.
- R5: A read of the status address clears the capture flag of every pin, whatever that pin's enable bit is. The read returns the flag values from before the clear.
- R6: If a rising edge arrives in the same cycle as a clearing read, that pin's flag stays set afterwards.
- R7: Reads of any address other than status (for example 0x2A) and all writes leave the capture flags unchanged.
- R8: `pin_oe` equals the direction register (1 = output). Writing status sets the output register, and `pin_out` shows it. For an output pin a status read returns the written bit. The mode bit has no effect on output pins.
- R9: `irq` = OR over pins of (status bit AND enable bit AND pin is an input).
- R10: A clearing read of status drops the interrupt contribution of an enabled capture-mode pin.
- R11: The enable bits do not change how status bits set, hold or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 7 | Raw asynchronous pin levels |
| pin_out | output | 7 | Output register levels |
| pin_oe | output | 7 | Per-pin output enable |
| irq | output | 1 | Combined GPIO interrupt |

## Verification
The hardest case to reach from the ports is a rising edge that lands in the very cycle a clearing read is sampled. The synchronizer hides the raw pin timing, so the stimulus must count edges. The bench raises the pin at a falling clock edge, lets two rising edges pass, and then presents the status read so that the third edge both samples the read and sees the edge. It then expects 0 from that read and 1 from the next. A table of direction, mode, enable, output and pin patterns covers the mixed cases. For each pattern it checks the first read, the repeat read and the interrupt line.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   typedef enum logic [2:0] {
      REG_NONE = 3'd0,
      REG_DIR  = 3'd1,
      REG_MASK = 3'd2,
      REG_MODE = 3'd3,
      REG_STAT = 3'd4
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic is_out,
   input  logic capture,
   input  logic out_val,
   input  logic clr_rd,
   output logic status,
   output logic rise_arm,
   output logic flag
);
   logic prev_q;
   logic flag_q;

   assign rise_arm = lvl & ~prev_q & capture & ~is_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= lvl;
         flag_q <= rise_arm | (flag_q & ~clr_rd);
      end
   end

   assign flag   = flag_q;
   assign status = is_out ? out_val : (capture ? flag_q : lvl);
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_edge_pkg::*;
#(
   parameter int          NPINS     = 7,
   parameter int          AW        = 8,
   parameter int          DW        = 8,
   parameter logic [7:0]  ADDR_DIR  = 8'h2C,
   parameter logic [7:0]  ADDR_MASK = 8'h2D,
   parameter logic [7:0]  ADDR_MODE = 8'h2E,
   parameter logic [7:0]  ADDR_STAT = 8'h2F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   input  logic [NPINS-1:0] status,
   output logic [DW-1:0]    bus_rdata,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] mask_q,
   output logic [NPINS-1:0] mode_q,
   output logic [NPINS-1:0] out_q,
   output logic             clr_rd
);
   gpio_reg_e    reg_sel;
   logic         wr_en;
   logic         rd_en;
   logic [DW-1:0] rd_mux;
   logic         unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DW-1:NPINS];

   always_comb begin
      if      (bus_addr == AW'(ADDR_DIR))  reg_sel = REG_DIR;
      else if (bus_addr == AW'(ADDR_MASK)) reg_sel = REG_MASK;
      else if (bus_addr == AW'(ADDR_MODE)) reg_sel = REG_MODE;
      else if (bus_addr == AW'(ADDR_STAT)) reg_sel = REG_STAT;
      else                                 reg_sel = REG_NONE;
   end

   assign wr_en  = bus_sel &  bus_wr;
   assign rd_en  = bus_sel & ~bus_wr;
   assign clr_rd = rd_en & (reg_sel == REG_STAT);

   always_comb begin
      rd_mux = '0;
      case (reg_sel)
         REG_DIR:  rd_mux[NPINS-1:0] = dir_q;
         REG_MASK: rd_mux[NPINS-1:0] = mask_q;
         REG_MODE: rd_mux[NPINS-1:0] = mode_q;
         REG_STAT: rd_mux[NPINS-1:0] = status;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q     <= '0;
         mask_q    <= '0;
         mode_q    <= '0;
         out_q     <= '0;
         bus_rdata <= '0;
      end else begin
         if (wr_en) begin
            case (reg_sel)
               REG_DIR:  dir_q  <= bus_wdata[NPINS-1:0];
               REG_MASK: mask_q <= bus_wdata[NPINS-1:0];
               REG_MODE: mode_q <= bus_wdata[NPINS-1:0];
               REG_STAT: out_q  <= bus_wdata[NPINS-1:0];
               default:  ;
            endcase
         end
         if (rd_en) bus_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
   parameter int          NPINS       = 7,
   parameter int          AW          = 8,
   parameter int          DW          = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  ADDR_DIR    = 8'h2C,
   parameter logic [7:0]  ADDR_MASK   = 8'h2D,
   parameter logic [7:0]  ADDR_MODE   = 8'h2E,
   parameter logic [7:0]  ADDR_STAT   = 8'h2F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             irq
);
   if (NPINS < 1 || NPINS >= DW) begin : g_bad_npins
      $error("NPINS must leave at least one reserved bit in the data word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_DIR == ADDR_MASK || ADDR_DIR == ADDR_MODE || ADDR_DIR == ADDR_STAT ||
       ADDR_MASK == ADDR_MODE || ADDR_MASK == ADDR_STAT || ADDR_MODE == ADDR_STAT) begin : g_bad_addr
      $error("register addresses must be distinct");
   end

   logic [NPINS-1:0] lvl_sync;
   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] mask_q;
   logic [NPINS-1:0] mode_q;
   logic [NPINS-1:0] out_q;
   logic [NPINS-1:0] status;
   logic [NPINS-1:0] rise_arm;
   logic [NPINS-1:0] edge_flag;
   logic             clr_rd;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_sync)
   );

   gpio_regfile #(
      .NPINS(NPINS), .AW(AW), .DW(DW),
      .ADDR_DIR(ADDR_DIR), .ADDR_MASK(ADDR_MASK),
      .ADDR_MODE(ADDR_MODE), .ADDR_STAT(ADDR_STAT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .status    (status),
      .bus_rdata (bus_rdata),
      .dir_q     (dir_q),
      .mask_q    (mask_q),
      .mode_q    (mode_q),
      .out_q     (out_q),
      .clr_rd    (clr_rd)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      gpio_pin_slice u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl      (lvl_sync[p]),
         .is_out   (dir_q[p]),
         .capture  (mode_q[p]),
         .out_val  (out_q[p]),
         .clr_rd   (clr_rd),
         .status   (status[p]),
         .rise_arm (rise_arm[p]),
         .flag     (edge_flag[p])
      );
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
   assign irq     = |(status & mask_q & ~dir_q);
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
   parameter int         NPINS     = 7,
   parameter int         AW        = 8,
   parameter int         DW        = 8,
   parameter logic [7:0] ADDR_STAT = 8'h2F
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [AW-1:0]    bus_addr,
   input logic [DW-1:0]    bus_wdata,
   input logic [DW-1:0]    bus_rdata,
   input logic [NPINS-1:0] pin_out,
   input logic             irq,
   input logic [NPINS-1:0] mask_q,
   input logic [NPINS-1:0] rise_arm,
   input logic [NPINS-1:0] edge_flag,
   input logic             clr_rd
);
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr) |=> (bus_rdata[DW-1:NPINS] == '0));

   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rd && rise_arm == '0) |=> (edge_flag == '0));

   a_r6_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
      clr_rd |=> ((edge_flag & $past(rise_arm)) == $past(rise_arm)));

   a_r7_only_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_rd |=> (($past(edge_flag) & ~edge_flag) == '0));

   a_r8_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == AW'(ADDR_STAT)) |=> (pin_out == $past(bus_wdata[NPINS-1:0])));

   a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(
   .NPINS(NPINS), .AW(AW), .DW(DW), .ADDR_STAT(ADDR_STAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .irq       (irq),
   .mask_q    (mask_q),
   .rise_arm  (rise_arm),
   .edge_flag (edge_flag),
   .clr_rd    (clr_rd)
);

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
   localparam logic [7:0] A_DIR  = 8'h2C;
   localparam logic [7:0] A_MASK = 8'h2D;
   localparam logic [7:0] A_MODE = 8'h2E;
   localparam logic [7:0] A_STAT = 8'h2F;
   localparam logic [7:0] A_GIRQ = 8'h2A;

   // fields: dir, mode, mask, outv, pins (7 bits each)
   localparam int NVEC = 6;
   localparam logic [34:0] VEC [NVEC] = '{
      {7'h00, 7'h00, 7'h7F, 7'h00, 7'h55},
      {7'h00, 7'h7F, 7'h00, 7'h00, 7'h2A},
      {7'h00, 7'h7F, 7'h7F, 7'h00, 7'h7F},
      {7'h0F, 7'h0F, 7'h7F, 7'h05, 7'h7F},
      {7'h70, 7'h03, 7'h03, 7'h50, 7'h0F},
      {7'h7F, 7'h00, 7'h7F, 7'h3C, 7'h7F}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [6:0] pin_in = '0;
   logic [6:0] pin_out;
   logic [6:0] pin_oe;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gpio_edge_port u_gpio_edge_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 rdata", bus_rdata, 8'h00);
      check("R1 irq", {7'b0, irq}, 8'h00);
      check("R1 pin_oe", {1'b0, pin_oe}, 8'h00);
      check("R1 pin_out", {1'b0, pin_out}, 8'h00);
      bus_read(A_DIR, rd);  check("R1 dir", rd, 8'h00);
      bus_read(A_MODE, rd); check("R1 mode", rd, 8'h00);
      bus_read(A_MASK, rd); check("R1 mask", rd, 8'h00);
      bus_read(A_STAT, rd); check("R1 status", rd, 8'h00);

      // R2 reserved bit 7
      bus_write(A_MODE, 8'hFF); bus_read(A_MODE, rd); check("R2 mode bit7", rd, 8'h7F);
      bus_write(A_MASK, 8'hFF); bus_read(A_MASK, rd); check("R2 mask bit7", rd, 8'h7F);

      // table walk: R3 R4 R5 R8 R9 R10
      for (int v = 0; v < NVEC; v++) begin
         logic [6:0] dir, mode, mask, outv, pins, e1, e2;
         {dir, mode, mask, outv, pins} = VEC[v];
         pin_in = '0; settle();
         bus_read(A_STAT, rd);
         bus_write(A_DIR, {1'b0, dir});
         bus_write(A_MODE, {1'b0, mode});
         bus_write(A_MASK, {1'b0, mask});
         bus_write(A_STAT, {1'b0, outv});
         @(negedge clk); pin_in = pins; settle();
         e1 = (dir & outv) | (~dir & pins);
         e2 = (dir & outv) | (~dir & ~mode & pins);
         check("R9 irq table", {7'b0, irq}, {7'b0, |(e1 & mask & ~dir)});
         check("R8 pin_out table", {1'b0, pin_out & dir}, {1'b0, outv & dir});
         check("R8 pin_oe table", {1'b0, pin_oe}, {1'b0, dir});
         bus_read(A_STAT, rd); check("R3/R4 first read", rd, {1'b0, e1});
         check("R10 irq after read", {7'b0, irq}, {7'b0, |(e2 & mask & ~dir)});
         bus_read(A_STAT, rd); check("R5/R3 repeat read", rd, {1'b0, e2});
      end

      // R7: global status read does not clear
      pin_in = '0; settle();
      bus_write(A_DIR, 8'h00); bus_write(A_MODE, 8'h01); bus_write(A_MASK, 8'h01);
      bus_read(A_STAT, rd);
      @(negedge clk); pin_in = 7'h01; settle();
      check("R9 irq edge pin", {7'b0, irq}, 8'h01);
      bus_read(A_GIRQ, rd); check("R7 unmapped reads 0", rd, 8'h00);
      check("R7 irq kept", {7'b0, irq}, 8'h01);
      bus_write(A_MODE, 8'h01);
      bus_read(A_STAT, rd); check("R7 flag kept", rd, 8'h01);
      check("R10 irq dropped", {7'b0, irq}, 8'h00);

      // R4 falling edge sets nothing
      @(negedge clk); pin_in = 7'h00; settle();
      bus_read(A_STAT, rd); check("R4 falling edge", rd, 8'h00);

      // R5/R11 masked edge pin clears on read, enable does not alter status
      bus_write(A_MASK, 8'h00);
      @(negedge clk); pin_in = 7'h01; settle();
      check("R11 irq masked", {7'b0, irq}, 8'h00);
      bus_write(A_MASK, 8'h01); bus_write(A_MASK, 8'h00);
      bus_read(A_STAT, rd); check("R11 status with mask toggled", rd, 8'h01);
      bus_read(A_STAT, rd); check("R5 masked cleared", rd, 8'h00);

      // R6 edge coincident with clearing read
      @(negedge clk); pin_in = 7'h00; settle();
      bus_read(A_STAT, rd);
      @(negedge clk); pin_in = 7'h01;
      @(posedge clk); @(posedge clk);
      bus_read(A_STAT, rd); check("R6 coincident read old", rd, 8'h00);
      bus_read(A_STAT, rd); check("R6 flag kept", rd, 8'h01);

      // R8 mode no effect on output pin
      bus_write(A_DIR, 8'h04); bus_write(A_MODE, 8'h04); bus_write(A_STAT, 8'h04);
      check("R8 pin_out high", {1'b0, pin_out}, 8'h04);
      bus_read(A_STAT, rd); check("R8 output read", rd & 8'h04, 8'h04);
      bus_read(A_STAT, rd); check("R8 output repeat", rd & 8'h04, 8'h04);
      bus_write(A_STAT, 8'h00);
      check("R8 pin_out low", {1'b0, pin_out}, 8'h00);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule